// File: doc/BRIEF.md
# Value-Predicted Load Consistency Checker

This block keeps a record of every cache-missing load that was handed a guessed value, so that dependent instructions can run ahead on it. When the true data comes back, the block decides whether that speculative work may stand or must be thrown away. It reports that decision as a single verdict pulse for the load's tag.

Comparing the returned data with the guess is not enough under a strongly ordered memory model. If another thread writes the same location while the guess is still outstanding, the early value may have come from a state that no legal ordering allows, even when the returned value happens to equal the guess. In strong mode the block therefore watches remote store addresses and marks any outstanding load whose cache line they touch. A marked load is always squashed. In relaxed mode, where dependent reads need no ordering, only the value comparison counts.

The tracker holds one slot per tag. Allocation stalls when every slot is occupied, and a flush wipes every slot at once without reporting any verdicts.

Top module: `vp_load_checker`

## Requirements
- R1: After reset no slot is occupied, `alloc_ready` is 1 and `vfy_valid` is 0.
- R2: An allocation is accepted when `alloc_valid` and `alloc_ready` are both 1. It fills the slot selected by the 3-bit `alloc_tag` (tags 0 to 7, one slot each) with the address and the predicted value.
- R3: `alloc_ready` is 0 while all 8 slots are occupied. An allocation offered while it is 0 changes no slot.
- R4: A fill to an occupied tag produces `vfy_valid` = 1 for exactly one cycle, in the cycle after the fill, with `vfy_tag` equal to the fill tag. `vfy_squash` is 1 when the fill data differs from the prediction and 0 when it matches, provided no ordering hazard exists. The slot is freed at the same edge.
- R5: A fill to an unoccupied tag produces no verdict.
- R6: In strong mode (`mode_strong` = 1), a remote store whose address bits above bit 5 equal those of an occupied slot marks that slot, whatever the offset bits 5:0 are. A marked slot gets `vfy_squash` = 1 even if the fill data matches. A store to a different 64-byte line has no effect.
- R7: In relaxed mode (`mode_strong` = 0), remote stores are ignored and the verdict depends only on the value comparison.
- R8: A snoop and a fill that hit the same slot in the same cycle in strong mode produce `vfy_squash` = 1.
- R9: `flush` empties every slot in one cycle and produces no verdict, including for a fill presented in the same cycle. A later fill of a flushed tag produces no verdict.
- R10: A freed slot that is allocated again starts with no hazard mark.
- R11: A snoop checks only the slots that were occupied before its cycle. A slot allocated in the same cycle as a matching snoop is not marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all slots, no verdicts |
| mode_strong | input | 1 | 1 = strong ordering with snooping, 0 = relaxed |
| alloc_valid | input | 1 | New predicted load offered |
| alloc_ready | output | 1 | At least one slot is free |
| alloc_tag | input | 3 | Slot index of the new load |
| alloc_addr | input | 32 | Byte address of the load |
| alloc_pred | input | 32 | Predicted value |
| fill_valid | input | 1 | Returned data present |
| fill_tag | input | 3 | Tag the data belongs to |
| fill_data | input | 32 | Returned data |
| snoop_valid | input | 1 | Remote store observed |
| snoop_addr | input | 32 | Remote store byte address |
| vfy_valid | output | 1 | One-cycle verdict pulse |
| vfy_tag | output | 3 | Tag of the verdict |
| vfy_squash | output | 1 | 1 = squash, 0 = prediction stands |

## Verification
Two functions can act on the same slot in one cycle: a fill that retires the slot and a snoop that would mark it. The bench provokes this by driving a fill with matching data and a same-line store on the same tag in one cycle. A verdict of squash shows that the snoop won. Two other collisions are driven the same way and judged at the ports by the verdict that follows. An allocation meeting a same-line snoop must give a clean verdict. A flush meeting a fill must give no pulse at all.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  parameter int unsigned VPC_TAG_W    = 3;
  parameter int unsigned VPC_ADDR_W   = 32;
  parameter int unsigned VPC_DATA_W   = 32;
  parameter int unsigned VPC_LINE_OFS = 6;

  // Verdict rule: any evidence of a wrong value or an ordering hazard squashes.
  function automatic logic vpc_squash(input logic value_differs, input logic order_risk);
    return value_differs | order_risk;
  endfunction
endpackage

// File: rtl/vpc_entry.sv
module vpc_entry #(
  parameter int unsigned ADDR_W   = vpc_pkg::VPC_ADDR_W,
  parameter int unsigned DATA_W   = vpc_pkg::VPC_DATA_W,
  parameter int unsigned LINE_OFS = vpc_pkg::VPC_LINE_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_hit,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [DATA_W-1:0] alloc_pred,
  input  logic              fill_hit,
  input  logic              snoop_en,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              live_o,
  output logic [DATA_W-1:0] pred_o,
  output logic              risk_o
);
  logic              valid_q;
  logic              hazard_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] pred_q;

  function automatic logic same_line(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    logic [ADDR_W-1:0] diff;
    diff = (a ^ b) >> LINE_OFS;
    return diff == '0;
  endfunction

  // Named internal events
  logic snoop_match;
  logic release_ev;
  assign snoop_match = valid_q & snoop_en & same_line(addr_q, snoop_addr);
  assign release_ev  = fill_hit & valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      hazard_q <= 1'b0;
      addr_q   <= '0;
      pred_q   <= '0;
    end else if (flush) begin
      valid_q  <= 1'b0;
      hazard_q <= 1'b0;
    end else begin
      if (snoop_match) hazard_q <= 1'b1;
      if (release_ev) begin
        valid_q  <= 1'b0;
        hazard_q <= 1'b0;
      end
      if (alloc_hit) begin
        valid_q  <= 1'b1;
        hazard_q <= 1'b0;
        addr_q   <= alloc_addr;
        pred_q   <= alloc_pred;
      end
    end
  end

  assign live_o = valid_q;
  assign pred_o = pred_q;
  assign risk_o = hazard_q | snoop_match;

  a_r2_alloc_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_hit && !flush) |=> valid_q);
  a_r6_hazard_only_live: assert property (@(posedge clk) disable iff (!rst_n)
    hazard_q |-> valid_q);
  a_r7_hazard_needs_strong: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hazard_q) |-> $past(snoop_en));
endmodule

// File: rtl/vpc_judge.sv
module vpc_judge #(
  parameter int unsigned TAG_W  = vpc_pkg::VPC_TAG_W,
  parameter int unsigned DATA_W = vpc_pkg::VPC_DATA_W,
  localparam int unsigned ENTRIES = 1 << TAG_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic                            fill_valid,
  input  logic [TAG_W-1:0]                fill_tag,
  input  logic [DATA_W-1:0]               fill_data,
  input  logic [ENTRIES-1:0]              live,
  input  logic [ENTRIES-1:0]              risk,
  input  logic [ENTRIES-1:0][DATA_W-1:0]  pred,
  output logic                            vfy_valid,
  output logic [TAG_W-1:0]                vfy_tag,
  output logic                            vfy_squash
);
  // Named internal events
  logic              sel_live;
  logic              sel_risk;
  logic [DATA_W-1:0] sel_pred;
  logic              verdict_ev;
  assign sel_live   = live[fill_tag];
  assign sel_risk   = risk[fill_tag];
  assign sel_pred   = pred[fill_tag];
  assign verdict_ev = fill_valid & sel_live & ~flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vfy_valid  <= 1'b0;
      vfy_tag    <= '0;
      vfy_squash <= 1'b0;
    end else begin
      vfy_valid  <= verdict_ev;
      vfy_tag    <= fill_tag;
      vfy_squash <= vpc_pkg::vpc_squash(sel_pred != fill_data, sel_risk);
    end
  end

  a_r4_pulse_follows_fill: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_valid |-> $past(fill_valid));
  a_r9_flush_silent: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !vfy_valid);
endmodule

// File: rtl/vp_load_checker.sv
module vp_load_checker #(
  parameter int unsigned TAG_W    = vpc_pkg::VPC_TAG_W,
  parameter int unsigned ADDR_W   = vpc_pkg::VPC_ADDR_W,
  parameter int unsigned DATA_W   = vpc_pkg::VPC_DATA_W,
  parameter int unsigned LINE_OFS = vpc_pkg::VPC_LINE_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              mode_strong,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [DATA_W-1:0] alloc_pred,
  input  logic              fill_valid,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              vfy_valid,
  output logic [TAG_W-1:0]  vfy_tag,
  output logic              vfy_squash
);
  localparam int unsigned ENTRIES = 1 << TAG_W;

  logic [ENTRIES-1:0]             live;
  logic [ENTRIES-1:0]             risk;
  logic [ENTRIES-1:0][DATA_W-1:0] pred;

  // Named internal events
  logic snoop_en;
  logic alloc_fire;
  assign snoop_en    = mode_strong & snoop_valid;
  assign alloc_ready = ~&live;
  assign alloc_fire  = alloc_valid & alloc_ready;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    vpc_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_OFS(LINE_OFS)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .alloc_hit  (alloc_fire && (alloc_tag == TAG_W'(i))),
      .alloc_addr (alloc_addr),
      .alloc_pred (alloc_pred),
      .fill_hit   (fill_valid && (fill_tag == TAG_W'(i))),
      .snoop_en   (snoop_en),
      .snoop_addr (snoop_addr),
      .live_o     (live[i]),
      .pred_o     (pred[i]),
      .risk_o     (risk[i])
    );
  end

  vpc_judge #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .fill_valid (fill_valid),
    .fill_tag   (fill_tag),
    .fill_data  (fill_data),
    .live       (live),
    .risk       (risk),
    .pred       (pred),
    .vfy_valid  (vfy_valid),
    .vfy_tag    (vfy_tag),
    .vfy_squash (vfy_squash)
  );

  a_r3_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (&live && !flush && !fill_valid) |=> &live);
endmodule

// File: tb/vp_load_checker_tb.sv
module vp_load_checker_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        flush = 0, mode_strong = 1;
  logic        alloc_valid = 0;
  logic        alloc_ready;
  logic [2:0]  alloc_tag = 0;
  logic [31:0] alloc_addr = 0, alloc_pred = 0;
  logic        fill_valid = 0;
  logic [2:0]  fill_tag = 0;
  logic [31:0] fill_data = 0;
  logic        snoop_valid = 0;
  logic [31:0] snoop_addr = 0;
  logic        vfy_valid, vfy_squash;
  logic [2:0]  vfy_tag;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vp_load_checker u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .mode_strong(mode_strong),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .alloc_addr(alloc_addr), .alloc_pred(alloc_pred),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .vfy_valid(vfy_valid), .vfy_tag(vfy_tag), .vfy_squash(vfy_squash)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [2:0] t, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    alloc_valid = 1; alloc_tag = t; alloc_addr = a; alloc_pred = d;
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic do_snoop(input logic [31:0] a);
    @(negedge clk);
    snoop_valid = 1; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 0;
  endtask

  task automatic check_verdict(input string req, input logic [2:0] t, input logic exp_v, input logic exp_sq);
    chk({req, " valid"}, 32'(vfy_valid), 32'(exp_v));
    if (exp_v) begin
      chk({req, " tag"}, 32'(vfy_tag), 32'(t));
      chk({req, " squash"}, 32'(vfy_squash), 32'(exp_sq));
    end
  endtask

  task automatic do_fill(input string req, input logic [2:0] t, input logic [31:0] d,
                         input logic exp_v, input logic exp_sq);
    @(negedge clk);
    fill_valid = 1; fill_tag = t; fill_data = d;
    @(negedge clk);
    fill_valid = 0;
    check_verdict(req, t, exp_v, exp_sq);
  endtask

  task automatic t_reset;
    chk("R1 ready", 32'(alloc_ready), 1);
    chk("R1 vfy", 32'(vfy_valid), 0);
  endtask

  task automatic t_value_compare;
    mode_strong = 1;
    do_alloc(3'd1, 32'h1000, 32'd5);
    do_fill("R2 R4 match", 3'd1, 32'd5, 1, 0);
    @(negedge clk);
    chk("R4 one-cycle pulse", 32'(vfy_valid), 0);
    do_alloc(3'd3, 32'h1100, 32'd7);
    do_fill("R4 mismatch", 3'd3, 32'd9, 1, 1);
    do_fill("R5 free tag", 3'd6, 32'd0, 0, 0);
  endtask

  task automatic t_strong_snoop;
    mode_strong = 1;
    do_alloc(3'd0, 32'h2040, 32'd11);
    do_snoop(32'h207C);
    do_fill("R6 same line squash", 3'd0, 32'd11, 1, 1);
    do_alloc(3'd2, 32'h3000, 32'd12);
    do_snoop(32'h3040);
    do_fill("R6 other line ok", 3'd2, 32'd12, 1, 0);
  endtask

  task automatic t_relaxed;
    mode_strong = 0;
    do_alloc(3'd4, 32'h4000, 32'd1);
    do_snoop(32'h4000);
    do_fill("R7 snoop ignored", 3'd4, 32'd1, 1, 0);
    do_alloc(3'd4, 32'h4000, 32'd2);
    do_fill("R7 value still checked", 3'd4, 32'd3, 1, 1);
    mode_strong = 1;
  endtask

  task automatic t_collisions;
    mode_strong = 1;
    do_alloc(3'd5, 32'h5000, 32'd8);
    @(negedge clk);
    fill_valid = 1; fill_tag = 3'd5; fill_data = 32'd8;
    snoop_valid = 1; snoop_addr = 32'h5010;
    @(negedge clk);
    fill_valid = 0; snoop_valid = 0;
    check_verdict("R8 snoop beats fill", 3'd5, 1, 1);
    @(negedge clk);
    alloc_valid = 1; alloc_tag = 3'd7; alloc_addr = 32'h7000; alloc_pred = 32'd9;
    snoop_valid = 1; snoop_addr = 32'h7000;
    @(negedge clk);
    alloc_valid = 0; snoop_valid = 0;
    do_fill("R11 new slot unmarked", 3'd7, 32'd9, 1, 0);
    do_alloc(3'd0, 32'h2040, 32'd11);
    do_fill("R10 reused slot clean", 3'd0, 32'd11, 1, 0);
  endtask

  task automatic t_full_and_flush;
    for (int i = 0; i < 8; i++) do_alloc(3'(i), 32'h100 * i, 32'(100 + i));
    chk("R3 ready low when full", 32'(alloc_ready), 0);
    do_alloc(3'd2, 32'h9999, 32'd999);
    do_fill("R3 stalled alloc ignored", 3'd2, 32'd102, 1, 0);
    chk("R4 slot freed", 32'(alloc_ready), 1);
    @(negedge clk);
    flush = 1; fill_valid = 1; fill_tag = 3'd3; fill_data = 32'd103;
    @(negedge clk);
    flush = 0; fill_valid = 0;
    chk("R9 no verdict on flush", 32'(vfy_valid), 0);
    chk("R9 ready after flush", 32'(alloc_ready), 1);
    do_fill("R9 flushed tag silent", 3'd4, 32'd104, 0, 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_value_compare;
    t_strong_snoop;
    t_relaxed;
    t_collisions;
    t_full_and_flush;
    done = 1;
    summary;
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary;
      $finish;
    end
  end
endmodule